// File: doc/BRIEF.md
# Prioritized Interrupt Service Tracker with End-of-Interrupt Decode

This block tracks which interrupt requests are waiting and which are being serviced, for a small fixed-priority set of sources. There is one shared level for a group of timer lines and one level for each external request line. A rising edge on a request line marks its level as pending. An acknowledge strobe moves the most urgent eligible pending level into service.

Software talks to the block through a 16-bit register bus with two addresses. The write-only end-of-interrupt register retires a level in one of two ways. With bit 15 set, it retires the most urgent level currently in service. With bit 15 clear, it retires the level named by the 5-bit type in bits 4:0. The read-only poll register shows whether anything is pending and gives the type of the most urgent pending level. The in-service levels are also visible as an output vector, so an interrupt front end can mask lower levels with it.

Top module: `icu_eoi_ctrl`

## Requirements
- R1: After reset no level is pending or in service: `in_service_o` is 0 and a poll read returns 16'h0000.
- R2: A rising edge on a request line sets its level pending. A line held high does not set it again after acknowledge. A pending level stays set until it is acknowledged.
- R3: All timer lines share one level (level 0, in-service bit 0), addressed as type 8. A specific clear written as 16'h0008 retires it.
- R4: A poll read (`reg_addr_i`=1) returns bit 15 = 1 when any level is pending. Bits 4:0 give the type of the most urgent pending level. All other bits read 0, and the whole word is 0 when nothing is pending.
- R5: When `ack_i` is high, the most urgent pending level that is more urgent than every in-service level is set in service and its pending bit is cleared. A level blocked by an equally or more urgent in-service level is not granted, and nothing changes.
- R6: Writing the end-of-interrupt register (`reg_addr_i`=0) with bit 15 set retires only the most urgent in-service level. It has no effect when nothing is in service.
- R7: Writing with bit 15 clear retires the level whose type is in bits 4:0. The types are 8 for the timer group and 12 to 15 for external lines 0 to 3, so 16'h000E retires external line 2 (in-service bit 3).
- R8: A specific clear that names a type with no level, or a level not in service, leaves `in_service_o` unchanged.
- R9: Reading address 0 returns 0, and a write to address 1 changes no state.
- R10: Priority is fixed: the timer group is the most urgent, then external lines 0, 1, 2 and 3 in that order. In-service bit i belongs to level i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_req_i | input | NUM_TMR | Timer request lines, shared level |
| ext_req_i | input | NUM_EXT | External request lines |
| ack_i | input | 1 | Acknowledge strobe, one cycle per grant |
| reg_addr_i | input | 1 | 0 = end-of-interrupt register, 1 = poll register |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected address |
| in_service_o | output | NUM_EXT+1 | In-service bits, bit 0 = timer group |

## Verification
The assertions assume that `ack_i` and the write strobe are single-cycle pulses driven from a clean clock domain. They also assume that reads are combinational, so the poll word can be checked with no bus handshake. The bench raises requests only on falling clock edges and always pulses acknowledge and writes for exactly one cycle. It sweeps every pattern of pending levels and every 5-bit clear type. It nests levels from the least urgent upward, so every in-service combination the checks rely on comes from legal grants.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned TYPE_W  = 5;
  localparam int unsigned FLAG_BIT = 15;

  typedef enum logic {
    SEL_EOI  = 1'b0,
    SEL_POLL = 1'b1
  } reg_sel_e;

  function automatic logic [TYPE_W-1:0] lvl_type(input int lvl, input int tmr_type,
                                                 input int ext_base);
    if (lvl == 0) return TYPE_W'(tmr_type);
    return TYPE_W'(ext_base + lvl - 1);
  endfunction
endpackage

// File: rtl/icu_prio_enc.sv
module icu_prio_enc #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [N-1:0] onehot_o
);
  // lowest index wins
  always_comb begin
    onehot_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) onehot_o = N'(1) << i;
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/icu_req_latch.sv
module icu_req_latch #(
  parameter int unsigned NUM_TMR = 3,
  parameter int unsigned NUM_EXT = 4,
  localparam int unsigned NUM_LVL = NUM_EXT + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_TMR-1:0] tmr_req_i,
  input  logic [NUM_EXT-1:0] ext_req_i,
  input  logic [NUM_LVL-1:0] clr_i,
  output logic [NUM_LVL-1:0] pend_o
);
  logic [NUM_TMR-1:0] tmr_q;
  logic [NUM_EXT-1:0] ext_q;
  logic [NUM_LVL-1:0] rise;

  assign rise[0] = |(tmr_req_i & ~tmr_q);
  for (genvar g = 0; g < int'(NUM_EXT); g++) begin : g_ext
    assign rise[g+1] = ext_req_i[g] & ~ext_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      ext_q  <= '0;
      pend_o <= '0;
    end else begin
      tmr_q  <= tmr_req_i;
      ext_q  <= ext_req_i;
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R2
endmodule

// File: rtl/icu_eoi_dec.sv
module icu_eoi_dec
  import icu_pkg::*;
#(
  parameter int unsigned NUM_LVL  = 5,
  parameter int unsigned TMR_TYPE = 8,
  parameter int unsigned EXT_BASE = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [NUM_LVL-1:0] isr_i,
  output logic [NUM_LVL-1:0] clr_o
);
  logic               nonspec;
  logic [TYPE_W-1:0]  typ;
  logic [NUM_LVL-1:0] top_oh;
  logic [NUM_LVL-1:0] hit;
  logic               top_v;

  assign nonspec = wdata_i[FLAG_BIT];
  assign typ     = wdata_i[TYPE_W-1:0];

  icu_prio_enc #(.N(NUM_LVL)) u_top (
    .req_i   (isr_i),
    .valid_o (top_v),
    .onehot_o(top_oh)
  );

  for (genvar g = 0; g < int'(NUM_LVL); g++) begin : g_hit
    assign hit[g] = (typ == lvl_type(g, int'(TMR_TYPE), int'(EXT_BASE)));
  end

  always_comb begin
    clr_o = '0;
    if (wr_i) clr_o = nonspec ? (top_v ? top_oh : '0) : (hit & isr_i);
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o)); // R7
endmodule

// File: rtl/icu_eoi_ctrl.sv
module icu_eoi_ctrl
  import icu_pkg::*;
#(
  parameter int unsigned NUM_TMR  = 3,
  parameter int unsigned NUM_EXT  = 4,
  parameter int unsigned TMR_TYPE = 8,
  parameter int unsigned EXT_BASE = 12,
  localparam int unsigned NUM_LVL = NUM_EXT + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_TMR-1:0] tmr_req_i,
  input  logic [NUM_EXT-1:0] ext_req_i,
  input  logic               ack_i,
  input  logic               reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic [NUM_LVL-1:0] in_service_o
);
  logic [NUM_LVL-1:0] pend, isr, elig, grant_oh, pend_clr, eoi_clr, poll_oh;
  logic               grant_v, poll_v, eoi_wr;
  logic [TYPE_W-1:0]  poll_typ;

  assign eoi_wr = reg_wr_i && (reg_sel_e'(reg_addr_i) == SEL_EOI);

  icu_req_latch #(.NUM_TMR(NUM_TMR), .NUM_EXT(NUM_EXT)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tmr_req_i(tmr_req_i),
    .ext_req_i(ext_req_i),
    .clr_i    (pend_clr),
    .pend_o   (pend)
  );

  // a level is eligible only if no equal or more urgent level is in service
  always_comb begin
    logic run;
    run = 1'b0;
    for (int i = 0; i < int'(NUM_LVL); i++) begin
      run     = run | isr[i];
      elig[i] = ~run;
    end
  end

  icu_prio_enc #(.N(NUM_LVL)) u_grant (
    .req_i   (pend & elig),
    .valid_o (grant_v),
    .onehot_o(grant_oh)
  );

  assign pend_clr = (ack_i && grant_v) ? grant_oh : '0;

  icu_eoi_dec #(.NUM_LVL(NUM_LVL), .TMR_TYPE(TMR_TYPE), .EXT_BASE(EXT_BASE)) u_eoi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (eoi_wr),
    .wdata_i(reg_wdata_i),
    .isr_i  (isr),
    .clr_o  (eoi_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr <= '0;
    else         isr <= (isr & ~eoi_clr) | pend_clr;
  end
  assign in_service_o = isr;

  icu_prio_enc #(.N(NUM_LVL)) u_poll (
    .req_i   (pend),
    .valid_o (poll_v),
    .onehot_o(poll_oh)
  );

  always_comb begin
    poll_typ = '0;
    for (int i = 0; i < int'(NUM_LVL); i++) begin
      if (poll_oh[i]) poll_typ |= lvl_type(i, int'(TMR_TYPE), int'(EXT_BASE));
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_e'(reg_addr_i) == SEL_POLL) begin
      reg_rdata_o[FLAG_BIT]     = poll_v;
      reg_rdata_o[TYPE_W-1:0]   = poll_typ;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(isr & ~$past(isr)) <= 1)); // R5
  AST_TMR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && isr[0] && !reg_wr_i) |=> $stable(isr)); // R5
  AST_NS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && reg_wdata_i[FLAG_BIT] && isr == '0 && !ack_i) |=> (isr == '0)); // R6
  AST_EOI_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !ack_i) |=> ((isr & ~$past(isr)) == '0)); // R8
endmodule

// File: tb/icu_eoi_ctrl_test.sv
module icu_eoi_ctrl_test;
  localparam int NT = 3;
  localparam int NE = 4;
  localparam int NL = NE + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] tmr = '0;
  logic [NE-1:0] ext = '0;
  logic          ack = 1'b0;
  logic          addr = 1'b0;
  logic          wr = 1'b0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [NL-1:0] isr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  icu_eoi_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .tmr_req_i(tmr), .ext_req_i(ext), .ack_i(ack),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .in_service_o(isr)
  );

  function automatic int type_of(input int lvl);
    return (lvl == 0) ? 8 : 11 + lvl;
  endfunction

  function automatic int lvl_of(input int t);
    if (t == 8) return 0;
    if (t >= 12 && t <= 15) return t - 11;
    return -1;
  endfunction

  function automatic logic [15:0] poll_exp(input logic [NL-1:0] p);
    for (int i = 0; i < NL; i++) if (p[i]) return 16'h8000 | 16'(type_of(i));
    return 16'h0000;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tmr = '0; ext = '0; ack = 1'b0; wr = 1'b0; addr = 1'b0; wdata = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic check_poll(input string req, input logic [15:0] exp);
    addr = 1'b1; #1;
    check(req, rdata, exp);
    addr = 1'b0;
  endtask

  task automatic pulse(input logic [NL-1:0] lv, input int tsel);
    if (lv[0]) tmr[tsel] = 1'b1;
    ext = lv[NL-1:1];
    tick();
    tmr = '0; ext = '0;
    tick();
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic reg_write(input logic a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1; tick(); wr = 1'b0; wdata = '0; addr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 isr", 16'(isr), 16'h0);
    check_poll("R1 poll", 16'h0000);
    addr = 1'b0; #1; check("R9 eoi reads zero", rdata, 16'h0);
    reg_write(1'b0, 16'h8000);
    check("R6 nonspecific idle", 16'(isr), 16'h0);
    do_ack();
    check("R5 ack with nothing pending", 16'(isr), 16'h0);

    // R10 R4 R5 R6: every pending pattern, drained by ack + nonspecific clear
    for (int pat = 1; pat < (1 << NL); pat++) begin
      logic [NL-1:0] ep;
      do_reset();
      ep = NL'(pat);
      pulse(ep, pat % NT);
      check_poll("R4 R10 poll sweep", poll_exp(ep));
      while (ep != '0) begin
        logic [NL-1:0] oh;
        oh = ep & (~ep + 1'b1);
        do_ack();
        ep &= ~oh;
        check("R5 grant most urgent", 16'(isr), 16'(oh));
        check_poll("R5 pending cleared", poll_exp(ep));
        reg_write(1'b0, 16'h8000);
        check("R6 nonspecific clears", 16'(isr), 16'h0);
      end
    end

    // R7 R8 R3: nest all levels, then every specific type
    for (int t = 0; t < 32; t++) begin
      logic [NL-1:0] e;
      do_reset();
      for (int l = NL - 1; l >= 0; l--) begin
        pulse(NL'(1) << l, t % NT);
        do_ack();
      end
      check("R5 nested grants", 16'(isr), 16'h1F);
      e = 5'h1F;
      if (lvl_of(t) >= 0) e[lvl_of(t)] = 1'b0;
      reg_write(1'b0, 16'(t));
      check("R7 R8 specific clear", 16'(isr), 16'(e));
      reg_write(1'b0, 16'(t));
      check("R8 repeat clear no effect", 16'(isr), 16'(e));
    end

    // R6 nonspecific retires only the most urgent of several
    do_reset();
    for (int l = NL - 1; l >= 0; l--) begin pulse(NL'(1) << l, 0); do_ack(); end
    reg_write(1'b0, 16'h8000);
    check("R6 only most urgent", 16'(isr), 16'h1E);
    reg_write(1'b1, 16'h8000);
    check("R9 poll write ignored", 16'(isr), 16'h1E);
    reg_write(1'b0, 16'h000E);
    check("R7 int2 type 14", 16'(isr), 16'h16);

    // R5 blocking by a more urgent in-service level; R3 timer sharing
    do_reset();
    tmr[2] = 1'b1; tick(); tmr = '0; tick();
    check_poll("R3 timer type 8", 16'h8008);
    do_ack();
    pulse(5'b00010, 0);
    do_ack();
    check("R5 blocked ack", 16'(isr), 16'h01);
    check_poll("R5 blocked stays pending", 16'h800C);
    reg_write(1'b0, 16'h0008);
    check("R3 type 8 clears timer", 16'(isr), 16'h00);
    do_ack();
    check("R5 unblocked grant", 16'(isr), 16'h02);

    // R2 held level latches once
    do_reset();
    ext[1] = 1'b1;
    tick(); tick();
    check_poll("R2 edge latched", 16'h800D);
    do_ack();
    tick(); tick();
    check_poll("R2 held no relatch", 16'h0000);
    reg_write(1'b0, 16'h000D);
    check("R2 cleared", 16'(isr), 16'h0);
    ext[1] = 1'b0; tick();
    ext[1] = 1'b1; tick(); tick();
    check_poll("R2 new edge", 16'h800D);
    ext = '0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule